// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Coprocessor

This arithmetic helper sits next to a 16-bit processor. Software loads 32-bit operands and an accumulator as 16-bit halves through a small write port and picks an operation in a control word. A one-cycle start pulse then launches a fixed-latency computation. The operations are a 16x16 multiply, a 16x16 product added to a 32-bit accumulator (wrapping or clamping), a 32-bit by 16-bit divide and a 32-bit by 32-bit divide. Any of them can treat its operands as two's-complement or as unsigned.

The block raises busy while it computes. It raises done when the result and the remainder can be read back as 16-bit halves. Each operation takes a fixed number of cycles, whatever the operand values are, so software can count cycles and does not need to poll. Dividing by zero and saturating are both reported on flags that can also be read from a status word.

Top module: `mdac_unit`

## Requirements
- R1: Mode 0 (control bits [1:0] = 0) multiplies op_a[15:0] by op_b[15:0] into a 32-bit result and sets the remainder to 0. done rises exactly 4 cycles after the accepted start edge, and busy is high in the cycles between.
- R2: Mode 1 forms op_a[15:0]*op_b[15:0] + acc in 4 cycles. When control bit 3 is 0, the result is the low 32 bits of the sum.
- R3: In mode 1 with control bit 3 set, an overflowing sum clamps. In unsigned mode it clamps to 0xFFFFFFFF. In signed mode it clamps to 0x7FFFFFFF or 0x80000000. A clamp also sets ovf_o, which stays set until the control word (write address 6) is written again.
- R4: Mode 2 divides the 32-bit op_a by op_b[15:0] (sign-extended in signed mode), giving a 32-bit quotient and a remainder, with done exactly 8 cycles after start.
- R5: Mode 3 divides the 32-bit op_a by the 32-bit op_b, with done exactly 16 cycles after start.
- R6: Control bit 2 selects signed operands. A signed quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R7: A zero divisor returns quotient 0xFFFFFFFF, returns op_a as the remainder and sets dz_o. dz_o clears at the next accepted start.
- R8: A start pulse or a register write that arrives while busy_o is high is ignored.
- R9: An accepted start clears done_o and dz_o on the next cycle, and busy_o is never high together with done_o.
- R10: After reset, busy_o, done_o, ovf_o and dz_o are 0, the result reads 0 and the mode is 0.
- R11: The write addresses are: 0/1 op_a low/high, 2/3 op_b low/high, 4/5 acc low/high, 6 control. The read addresses are: 0/1 result low/high, 2/3 remainder low/high, 4 status {ovf, dz, done, busy} in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| start_i | input | 1 | Launch operation (one-cycle pulse) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid |
| ovf_o | output | 1 | Sticky saturation flag |
| dz_o | output | 1 | Last division had a zero divisor |

## Verification
Take the clock edge that samples start as edge 0. For an operation of latency N (4, 8 or 16 cycles), busy must be high and done low after each of edges 0 to N-1. After edge N, busy must be low and done high, and only then are the result, remainder and flags due. The bench drives inputs on falling edges and samples busy and done after every falling edge up to the Nth. It reads the results only once done has been seen, so a design that is early or late by a single cycle fails the latency check. The check for an ignored start counts the expected latency from the first start. A second operation, started with no writes in between, then proves that the operand write made during busy never landed.

// File: rtl/mdac_pkg.sv
`timescale 1ns/1ps
package mdac_pkg;
  localparam int OPW      = 16;
  localparam int DW       = 2 * OPW;
  localparam int MUL_LAT  = 4;
  localparam int MAC_LAT  = 4;
  localparam int D16_LAT  = 8;
  localparam int D32_LAT  = 16;
  localparam int CNTW     = $clog2(D32_LAT);
  localparam int MUL_NIB  = OPW / MUL_LAT;
  localparam int MUL_IDXW = $clog2(MUL_LAT);
  localparam int D16_BITS = DW / D16_LAT;
  localparam int D32_BITS = DW / D32_LAT;
  localparam int DIV_MAXB = (D16_BITS > D32_BITS) ? D16_BITS : D32_BITS;
  localparam int NBW      = $clog2(DIV_MAXB + 1);
  localparam int AW       = 3;

  typedef enum logic [1:0] {
    M_MUL   = 2'd0,
    M_MAC   = 2'd1,
    M_DIV16 = 2'd2,
    M_DIV32 = 2'd3
  } mode_e;

  localparam logic [AW-1:0] A_OPA_LO = 3'd0;
  localparam logic [AW-1:0] A_OPA_HI = 3'd1;
  localparam logic [AW-1:0] A_OPB_LO = 3'd2;
  localparam logic [AW-1:0] A_OPB_HI = 3'd3;
  localparam logic [AW-1:0] A_ACC_LO = 3'd4;
  localparam logic [AW-1:0] A_ACC_HI = 3'd5;
  localparam logic [AW-1:0] A_CTRL   = 3'd6;

  localparam logic [AW-1:0] R_RES_LO = 3'd0;
  localparam logic [AW-1:0] R_RES_HI = 3'd1;
  localparam logic [AW-1:0] R_REM_LO = 3'd2;
  localparam logic [AW-1:0] R_REM_HI = 3'd3;
  localparam logic [AW-1:0] R_STAT   = 3'd4;

  function automatic int unsigned lat_of(mode_e m);
    case (m)
      M_MUL:   return MUL_LAT;
      M_MAC:   return MAC_LAT;
      M_DIV16: return D16_LAT;
      default: return D32_LAT;
    endcase
  endfunction
endpackage

// File: rtl/mdac_mul_step.sv
`timescale 1ns/1ps
// One radix-2^NIB partial-product step of an unsigned shift-add multiplier.
module mdac_mul_step #(
  parameter int OPW  = 16,
  parameter int DW   = 32,
  parameter int NIB  = 4,
  localparam int STEPS = OPW / NIB,
  localparam int IDXW  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic [DW-1:0]   prod_i,
  input  logic [OPW-1:0]  mcand_i,
  input  logic [OPW-1:0]  mplier_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [DW-1:0]   prod_o
);
  logic [NIB-1:0] digit;
  logic [DW-1:0]  pp;

  always_comb begin
    digit  = mplier_i[idx_i*NIB +: NIB];
    pp     = DW'(mcand_i) * DW'(digit);
    prod_o = prod_i + (pp << (idx_i * NIB));
  end
endmodule

// File: rtl/mdac_div_step.sv
`timescale 1ns/1ps
// Restoring division: retires up to MAXB quotient bits per call, nbits_i chosen at run time.
module mdac_div_step #(
  parameter int DW   = 32,
  parameter int MAXB = 4,
  localparam int NBW = $clog2(MAXB + 1)
) (
  input  logic [DW-1:0]  rem_i,
  input  logic [DW-1:0]  quo_i,
  input  logic [DW-1:0]  dvs_i,
  input  logic [NBW-1:0] nbits_i,
  output logic [DW-1:0]  rem_o,
  output logic [DW-1:0]  quo_o
);
  logic [DW:0]   trial;
  logic [DW-1:0] r, q;

  always_comb begin
    r     = rem_i;
    q     = quo_i;
    trial = '0;
    for (int i = 0; i < MAXB; i++) begin
      if (NBW'(i) < nbits_i) begin
        trial = {r, q[DW-1]};
        q     = {q[DW-2:0], 1'b0};
        if (trial >= {1'b0, dvs_i}) begin
          trial = trial - {1'b0, dvs_i};
          q[0]  = 1'b1;
        end
        r = trial[DW-1:0];
      end
    end
    rem_o = r;
    quo_o = q;
  end
endmodule

// File: rtl/mdac_unit.sv
`timescale 1ns/1ps
module mdac_unit
  import mdac_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [OPW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [OPW-1:0] rd_data_o,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ovf_o,
  output logic          dz_o
);
  // programmer-visible state
  logic [DW-1:0] op_a_q, op_b_q, acc_q, res_q, rem_q;
  mode_e         mode_q;
  logic          sgn_q, sat_q;
  logic          busy_q, done_q, ovf_q, dz_q;

  // run state
  logic [CNTW-1:0] cnt_q;
  mode_e           run_mode_q;
  logic            run_sgn_q, run_sat_q, neg_q_q, neg_r_q, zdiv_q;
  logic [OPW-1:0]  m_a_q, m_b_q;
  logic [DW-1:0]   w_p_q, w_rem_q, w_quo_q, w_div_q;

  logic wr_ok, start_ok;
  assign wr_ok    = wr_en_i && !busy_q;
  assign start_ok = start_i && !busy_q;

  // operand preparation at start
  logic           a_neg16, b_neg16, dvd_neg, dvs_neg, is_div;
  logic [OPW-1:0] mag_a16, mag_b16;
  logic [DW-1:0]  dvs_raw, mag_dvd, mag_dvs;

  always_comb begin
    is_div  = (mode_q == M_DIV16) || (mode_q == M_DIV32);
    a_neg16 = sgn_q & op_a_q[OPW-1];
    b_neg16 = sgn_q & op_b_q[OPW-1];
    mag_a16 = a_neg16 ? -op_a_q[OPW-1:0] : op_a_q[OPW-1:0];
    mag_b16 = b_neg16 ? -op_b_q[OPW-1:0] : op_b_q[OPW-1:0];
    if (mode_q == M_DIV16)
      dvs_raw = {{OPW{sgn_q & op_b_q[OPW-1]}}, op_b_q[OPW-1:0]};
    else
      dvs_raw = op_b_q;
    dvd_neg = sgn_q & op_a_q[DW-1];
    dvs_neg = sgn_q & dvs_raw[DW-1];
    mag_dvd = dvd_neg ? -op_a_q : op_a_q;
    mag_dvs = dvs_neg ? -dvs_raw : dvs_raw;
  end

  // iteration datapath
  logic [MUL_IDXW-1:0] mul_idx;
  logic [NBW-1:0]      div_nbits;
  logic [DW-1:0]       mul_out, rem_out, quo_out;

  assign mul_idx   = MUL_IDXW'(MUL_LAT - 1) - cnt_q[MUL_IDXW-1:0];
  assign div_nbits = (run_mode_q == M_DIV16) ? NBW'(D16_BITS) : NBW'(D32_BITS);

  mdac_mul_step #(.OPW(OPW), .DW(DW), .NIB(MUL_NIB)) u_mul (
    .prod_i  (w_p_q),
    .mcand_i (m_a_q),
    .mplier_i(m_b_q),
    .idx_i   (mul_idx),
    .prod_o  (mul_out)
  );

  mdac_div_step #(.DW(DW), .MAXB(DIV_MAXB)) u_div (
    .rem_i  (w_rem_q),
    .quo_i  (w_quo_q),
    .dvs_i  (w_div_q),
    .nbits_i(div_nbits),
    .rem_o  (rem_out),
    .quo_o  (quo_out)
  );

  // final fix-up on the last iteration
  logic [DW-1:0] prod_s, sat_val, fin_res, fin_rem;
  logic [DW:0]   sum_x;
  logic          ovf_hit;

  always_comb begin
    prod_s = neg_q_q ? -mul_out : mul_out;
    if (run_sgn_q) begin
      sum_x   = {prod_s[DW-1], prod_s} + {acc_q[DW-1], acc_q};
      ovf_hit = sum_x[DW] ^ sum_x[DW-1];
      sat_val = sum_x[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    end else begin
      sum_x   = {1'b0, prod_s} + {1'b0, acc_q};
      ovf_hit = sum_x[DW];
      sat_val = '1;
    end
    fin_rem = '0;
    case (run_mode_q)
      M_MUL: fin_res = prod_s;
      M_MAC: fin_res = (run_sat_q && ovf_hit) ? sat_val : sum_x[DW-1:0];
      default: begin
        fin_res = zdiv_q ? '1     : (neg_q_q ? -quo_out : quo_out);
        fin_rem = zdiv_q ? op_a_q : (neg_r_q ? -rem_out : rem_out);
      end
    endcase
  end

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q <= '0;
      op_b_q <= '0;
      acc_q  <= '0;
      mode_q <= M_MUL;
      sgn_q  <= 1'b0;
      sat_q  <= 1'b0;
    end else if (wr_ok) begin
      case (wr_addr_i)
        A_OPA_LO: op_a_q[OPW-1:0]  <= wr_data_i;
        A_OPA_HI: op_a_q[DW-1:OPW] <= wr_data_i;
        A_OPB_LO: op_b_q[OPW-1:0]  <= wr_data_i;
        A_OPB_HI: op_b_q[DW-1:OPW] <= wr_data_i;
        A_ACC_LO: acc_q[OPW-1:0]   <= wr_data_i;
        A_ACC_HI: acc_q[DW-1:OPW]  <= wr_data_i;
        A_CTRL: begin
          mode_q <= mode_e'(wr_data_i[1:0]);
          sgn_q  <= wr_data_i[2];
          sat_q  <= wr_data_i[3];
        end
        default: ;
      endcase
    end
  end

  // sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      ovf_q      <= 1'b0;
      dz_q       <= 1'b0;
      cnt_q      <= '0;
      run_mode_q <= M_MUL;
      run_sgn_q  <= 1'b0;
      run_sat_q  <= 1'b0;
      neg_q_q    <= 1'b0;
      neg_r_q    <= 1'b0;
      zdiv_q     <= 1'b0;
      m_a_q      <= '0;
      m_b_q      <= '0;
      w_p_q      <= '0;
      w_rem_q    <= '0;
      w_quo_q    <= '0;
      w_div_q    <= '0;
      res_q      <= '0;
      rem_q      <= '0;
    end else begin
      if (wr_ok && wr_addr_i == A_CTRL) ovf_q <= 1'b0;
      if (start_ok) begin
        busy_q     <= 1'b1;
        done_q     <= 1'b0;
        dz_q       <= 1'b0;
        cnt_q      <= CNTW'(lat_of(mode_q) - 1);
        run_mode_q <= mode_q;
        run_sgn_q  <= sgn_q;
        run_sat_q  <= sat_q;
        neg_q_q    <= is_div ? (dvd_neg ^ dvs_neg) : (a_neg16 ^ b_neg16);
        neg_r_q    <= dvd_neg;
        zdiv_q     <= is_div && (dvs_raw == '0);
        m_a_q      <= mag_a16;
        m_b_q      <= mag_b16;
        w_p_q      <= '0;
        w_rem_q    <= '0;
        w_quo_q    <= mag_dvd;
        w_div_q    <= mag_dvs;
      end else if (busy_q) begin
        w_p_q   <= mul_out;
        w_rem_q <= rem_out;
        w_quo_q <= quo_out;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= fin_res;
          rem_q  <= fin_rem;
          dz_q   <= zdiv_q;
          if (run_mode_q == M_MAC && run_sat_q && ovf_hit) ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // read port
  always_comb begin
    case (rd_addr_i)
      R_RES_LO: rd_data_o = res_q[OPW-1:0];
      R_RES_HI: rd_data_o = res_q[DW-1:OPW];
      R_REM_LO: rd_data_o = rem_q[OPW-1:0];
      R_REM_HI: rd_data_o = rem_q[DW-1:OPW];
      R_STAT:   rd_data_o = {{(OPW-4){1'b0}}, ovf_q, dz_q, done_q, busy_q};
      default:  rd_data_o = '0;
    endcase
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;
  assign dz_o   = dz_q;
endmodule

// File: rtl/mdac_unit_chk.sv
`timescale 1ns/1ps
module mdac_unit_chk
  import mdac_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ovf_o,
  input logic          dz_o,
  input mode_e         mode_q,
  input logic [DW-1:0] op_a_q,
  input logic [DW-1:0] op_b_q,
  input logic [DW-1:0] acc_q
);
  logic [CNTW:0] since_q;
  mode_e         exp_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q    <= '0;
      exp_mode_q <= M_MUL;
    end else if (start_i && !busy_o) begin
      since_q    <= '0;
      exp_mode_q <= mode_q;
    end else if (busy_o) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> since_q == (CNTW+1)'(lat_of(exp_mode_q))); // R1 R2 R4 R5
  AST_BUSY_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R9
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o && !dz_o)); // R9
  AST_OPS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(op_a_q) && $stable(op_b_q) && $stable(acc_q))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(wr_en_i && !busy_o && wr_addr_i == A_CTRL)) |=> ovf_o); // R3
  AST_DZ_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |-> done_o); // R7
endmodule

bind mdac_unit mdac_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ovf_o     (ovf_o),
  .dz_o      (dz_o),
  .mode_q    (mode_q),
  .op_a_q    (op_a_q),
  .op_b_q    (op_b_q),
  .acc_q     (acc_q)
);

// File: tb/mdac_unit_bench.sv
`timescale 1ns/1ps
module mdac_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        start_i = 1'b0;
  logic        busy_o, done_o, ovf_o, dz_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  mdac_unit u_mdac_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .start_i(start_i), .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o), .dz_o(dz_o)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sgn;
    logic        sat;
    logic [31:0] a, b, acc, res, rem;
    logic        ovf, dz;
  } vec_t;

  localparam int NV = 14;
  // mode, sgn, sat, a, b, acc, expected result, expected remainder, ovf, dz
  localparam logic [165:0] VECS [NV] = '{
    {2'd0, 1'b0, 1'b0, 32'h0000FFFF, 32'h0000FFFF, 32'h0, 32'hFFFE0001, 32'h0, 1'b0, 1'b0}, // R1
    {2'd0, 1'b1, 1'b0, 32'h0000FFFE, 32'h00000003, 32'h0, 32'hFFFFFFFA, 32'h0, 1'b0, 1'b0}, // R6
    {2'd0, 1'b1, 1'b0, 32'h00008000, 32'h00008000, 32'h0, 32'h40000000, 32'h0, 1'b0, 1'b0}, // R6
    {2'd1, 1'b0, 1'b0, 32'h00000002, 32'h00000003, 32'hFFFFFFFF, 32'h00000005, 32'h0, 1'b0, 1'b0}, // R2
    {2'd1, 1'b0, 1'b1, 32'h00000002, 32'h00000003, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b0}, // R3
    {2'd1, 1'b1, 1'b1, 32'h00007FFF, 32'h00007FFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h0, 1'b1, 1'b0}, // R3
    {2'd1, 1'b1, 1'b1, 32'h00008000, 32'h00007FFF, 32'h80000000, 32'h80000000, 32'h0, 1'b1, 1'b0}, // R3
    {2'd1, 1'b1, 1'b0, 32'h0000FFFF, 32'h00000005, 32'h00000010, 32'h0000000B, 32'h0, 1'b0, 1'b0}, // R6
    {2'd2, 1'b0, 1'b0, 32'h000186A0, 32'h00000007, 32'h0, 32'h000037CD, 32'h5, 1'b0, 1'b0}, // R4
    {2'd2, 1'b1, 1'b0, 32'hFFFFFFF9, 32'h00000002, 32'h0, 32'hFFFFFFFD, 32'hFFFFFFFF, 1'b0, 1'b0}, // R6
    {2'd3, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00010000, 32'h0, 32'h0000FFFF, 32'h0000FFFF, 1'b0, 1'b0}, // R5
    {2'd3, 1'b1, 1'b0, 32'h00000007, 32'hFFFFFFFE, 32'h0, 32'hFFFFFFFD, 32'h00000001, 1'b0, 1'b0}, // R6
    {2'd3, 1'b1, 1'b0, 32'hFFFFFFF9, 32'h00000000, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFF9, 1'b0, 1'b1}, // R7
    {2'd2, 1'b0, 1'b0, 32'h12345678, 32'h00050000, 32'h0, 32'hFFFFFFFF, 32'h12345678, 1'b0, 1'b1}  // R7
  };

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] addr, input logic [15:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd32(input logic [2:0] lo_addr, output logic [31:0] val);
    rd_addr_i = lo_addr;
    #0.5;
    val[15:0] = rd_data_o;
    rd_addr_i = lo_addr + 3'd1;
    #0.5;
    val[31:16] = rd_data_o;
  endtask

  function automatic int lat_for(input logic [1:0] m);
    return (m == 2'd2) ? 8 : (m == 2'd3) ? 16 : 4;
  endfunction

  // start pulse, then check busy/done at every falling edge up to the latency
  task automatic do_op(input int lat, input string tag);
    logic ok;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && !done_o && !dz_o, "R9", "start clears done", {29'b0, busy_o, done_o, dz_o}, 32'h4);
    ok = 1'b1;
    for (int k = 1; k < lat; k++) begin
      @(negedge clk_i);
      if (!(busy_o && !done_o)) ok = 1'b0;
    end
    @(negedge clk_i);
    if (!(done_o && !busy_o)) ok = 1'b0;
    chk(ok, tag, "latency", {30'b0, busy_o, done_o}, 32'h1);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    logic [31:0] r;
    wr(3'd6, {12'b0, v.sat, v.sgn, v.mode});
    wr(3'd0, v.a[15:0]);   wr(3'd1, v.a[31:16]);
    wr(3'd2, v.b[15:0]);   wr(3'd3, v.b[31:16]);
    wr(3'd4, v.acc[15:0]); wr(3'd5, v.acc[31:16]);
    do_op(lat_for(v.mode), tag);
    rd32(3'd0, r); chk(r == v.res, tag, "result", r, v.res);
    rd32(3'd2, r); chk(r == v.rem, tag, "remainder", r, v.rem);
    chk(ovf_o == v.ovf, tag, "ovf", {31'b0, ovf_o}, {31'b0, v.ovf});
    chk(dz_o == v.dz, tag, "dz", {31'b0, dz_o}, {31'b0, v.dz});
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.dz) return "R7";
    if (v.sat) return "R3";
    if (v.sgn) return "R6";
    case (v.mode)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin : watchdog
    #100000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    rd32(3'd0, r);
    chk(!busy_o && !done_o && !ovf_o && !dz_o && r == 32'h0, "R10", "reset state",
        {r[27:0], busy_o, done_o, ovf_o, dz_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd32(3'd0, r);
    chk(r == 32'h0 && !busy_o, "R10", "after release", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      run_vec(v, tag_of(v));
    end

    // R11 status word after zero-divide vector: ovf=0 dz=1 done=1 busy=0
    rd_addr_i = 3'd4; #0.5;
    chk(rd_data_o == 16'h0006, "R11", "status word", {16'b0, rd_data_o}, 32'h6);

    // R3 sticky overflow survives a clean saturating op, cleared by control write
    wr(3'd6, 16'h0009);
    wr(3'd0, 16'h0002); wr(3'd1, 16'h0); wr(3'd2, 16'h0003); wr(3'd3, 16'h0);
    wr(3'd4, 16'hFFFF); wr(3'd5, 16'hFFFF);
    do_op(4, "R3");
    chk(ovf_o, "R3", "ovf set", {31'b0, ovf_o}, 32'h1);
    wr(3'd4, 16'h0); wr(3'd5, 16'h0);
    do_op(4, "R3");
    rd32(3'd0, r);
    chk(r == 32'h6, "R3", "clean sat result", r, 32'h6);
    chk(ovf_o, "R3", "ovf sticky", {31'b0, ovf_o}, 32'h1);
    wr(3'd6, 16'h0009);
    chk(!ovf_o, "R3", "ovf cleared by control write", {31'b0, ovf_o}, 32'h0);

    // R8 start and write during busy are ignored
    wr(3'd6, 16'h0003);
    wr(3'd0, 16'd100); wr(3'd1, 16'h0); wr(3'd2, 16'd7); wr(3'd3, 16'h0);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 16'h0500;
    @(negedge clk_i);
    start_i = 1'b0; wr_en_i = 1'b0;
    repeat (14) @(negedge clk_i);
    chk(done_o && !busy_o, "R8", "latency kept from first start", {30'b0, busy_o, done_o}, 32'h1);
    @(negedge clk_i);
    chk(!busy_o && done_o, "R8", "no restart", {30'b0, busy_o, done_o}, 32'h1);
    rd32(3'd0, r);
    chk(r == 32'd14, "R8", "quotient", r, 32'd14);
    do_op(16, "R5");
    rd32(3'd0, r);
    chk(r == 32'd14, "R8", "busy write dropped", r, 32'd14);
    rd32(3'd2, r);
    chk(r == 32'd2, "R8", "remainder", r, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule